// File: doc/BRIEF.md
# Parallel Port Compatibility-Mode Receiver

This block is the peripheral end of a host-to-printer parallel port working in IEEE 1284 compatibility mode. The host places a byte on eight data lines and pulses an active-low strobe. The block passes every host line through a two-stage synchroniser and detects the strobe's falling edge on the synchronised copy. It captures the byte on that edge and raises BUSY on the same clock edge. It then writes the byte into an internal receive FIFO, pulses an active-low ACK for a set number of clocks, and drops BUSY when the pulse ends. Downstream logic drains the FIFO through a valid/ready port.

When the FIFO has no room, the byte waits in a holding register. BUSY stays high and no ACK is sent until a slot frees up. Paper-empty, select and fault status come from internal inputs. A paper-empty or fault condition also forces BUSY high. The input-prime line can be honoured or ignored under a configuration input. When it is honoured, an asserted input-prime empties the FIFO, abandons any handshake in progress and produces a one-clock reset request. The select-in and auto-feed lines are synchronised and given out active high.

Top module: `pport_rx`

## Requirements
- R1: Data lines are synchronised through the same two stages as the strobe. The byte captured is the one present when the synchronised strobe is seen falling, so the host-side strobe fall makes BUSY rise on the third rising clock edge after the fall.
- R2: BUSY rises on the same clock edge at which the byte is captured into the holding register.
- R3: When the FIFO has room, the captured byte is written on the clock edge after capture, so `rd_valid` can rise one edge after BUSY.
- R4: ACK (`ack_n`, active low) goes low on the edge that writes the byte and stays low for exactly ACK_W clocks. BUSY stays high throughout and falls on the same edge at which `ack_n` returns high.
- R5: While the FIFO holds DEPTH bytes, a captured byte stays in the holding register with BUSY high and `ack_n` high. It is written, and then acknowledged, on the edge after a slot frees.
- R6: The FIFO read side is first-in first-out. `rd_data` is valid while `rd_valid` is high, and one entry is removed on each edge where both `rd_valid` and `rd_ready` are high.
- R7: With `iprime_en` high, a synchronised low on `init_n` empties the FIFO and returns the handshake to idle on every edge it is seen. `reset_req` is high for exactly one clock, one edge after the synchronised falling edge of `init_n`.
- R8: With `iprime_en` low, `init_n` has no effect: the FIFO contents and the handshake are kept, and `reset_req` stays low.
- R9: `pe` equals `paper_out`, `sel` equals `online` and `fault_n` equals the inverse of `fault`, with no clock delay. BUSY is high whenever `paper_out` or `fault` is high.
- R10: `host_select` is the inverse of `selin_n` and `autofeed` is the inverse of `autofd_n`, each delayed by two clock edges.
- R11: A strobe falling edge seen while a handshake is in progress (holding or acknowledging) is ignored, and its byte is never stored.
- R12: After reset, BUSY is low, `ack_n` is high, `rd_valid` is low and `reset_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| iprime_en | input | 1 | Configuration: honour the input-prime line |
| strobe_n | input | 1 | Host data strobe, active low |
| data_in | input | 8 | Host data lines |
| init_n | input | 1 | Host input-prime line, active low |
| selin_n | input | 1 | Host select-in line, active low |
| autofd_n | input | 1 | Host auto-feed line, active low |
| paper_out | input | 1 | Internal paper-empty status |
| online | input | 1 | Internal selected/online status |
| fault | input | 1 | Internal fault status |
| busy | output | 1 | BUSY to host, active high |
| ack_n | output | 1 | Acknowledge to host, active low |
| pe | output | 1 | Paper-empty to host |
| sel | output | 1 | Select to host |
| fault_n | output | 1 | Fault to host, active low |
| host_select | output | 1 | Synchronised select-in request, active high |
| autofeed | output | 1 | Synchronised auto-feed request, active high |
| reset_req | output | 1 | One-clock reset request from input-prime |
| rd_valid | output | 1 | FIFO has a byte for the consumer |
| rd_data | output | 8 | Oldest byte in the FIFO |
| rd_ready | input | 1 | Consumer accepts the byte |

## Verification
The hardest case to reach is a byte stuck in the holding register behind a full FIFO. To get there, the host must deliver more bytes than the FIFO holds while the consumer stays idle, and the bench must then release a single slot to watch the delayed store and ACK. A second hard case is a stray strobe arriving during an acknowledge. A third is input-prime arriving in the middle of a handshake, which calls for tight timing between the strobe and the prime line. The bench sequences these cases with the consumer held off. A behavioural model built from queues and counters predicts every output on every clock, and the bytes drained at the read port are compared with the bytes the host intended to deliver.

// File: rtl/pport_pkg.sv
package pport_pkg;

    localparam int BYTE_W = 8;

    // Host-side lines gathered so that one synchroniser serves them all
    typedef struct packed {
        logic              strobe_n;
        logic              init_n;
        logic              selin_n;
        logic              autofd_n;
        logic [BYTE_W-1:0] data;
    } host_lines_t;

    localparam int HOST_W = $bits(host_lines_t);

    // Inactive level of every host line, used as the synchroniser reset value
    localparam host_lines_t HOST_IDLE = '{
        strobe_n: 1'b1,
        init_n:   1'b1,
        selin_n:  1'b1,
        autofd_n: 1'b1,
        data:     '0
    };

    typedef enum logic [1:0] {
        HS_IDLE = 2'd0,
        HS_HOLD = 2'd1,
        HS_ACK  = 2'd2
    } hs_state_t;

    // Width of a counter that must hold values 0..n
    function automatic int unsigned cnt_w(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/pport_sync.sv
module pport_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= RST_VAL;
            stage2 <= RST_VAL;
        end else begin
            stage1 <= d;
            stage2 <= stage1;
        end
    end

    assign q = stage2;
endmodule

// File: rtl/pport_fifo.sv
module pport_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic             full,
    output logic             rd_valid,
    output logic [WIDTH-1:0] rd_data,
    input  logic             rd_ready
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = pport_pkg::cnt_w(DEPTH);
    localparam logic [AW-1:0] LAST  = AW'(DEPTH - 1);
    localparam logic [CW-1:0] MAXC  = CW'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp;
    logic [AW-1:0]    rp;
    logic [CW-1:0]    count;
    logic             push;
    logic             pop;

    function automatic logic [AW-1:0] adv(input logic [AW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    assign full     = (count == MAXC);
    assign rd_valid = (count != '0);
    assign rd_data  = mem[rp];
    assign push     = wr_en & ~full;
    assign pop      = rd_ready & rd_valid;

    always_ff @(posedge clk) begin
        if (push && !flush) begin
            mem[wp] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push) wp <= adv(wp);
            if (pop)  rp <= adv(rp);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (full && !pop && !flush) |=> (count == MAXC)) else $error("overflow"); // R5
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
        flush |=> !rd_valid) else $error("flush left data"); // R7
    AST_POP_ORDER: assert property (@(posedge clk) disable iff (rst)
        (pop && !push && !flush) |=> (count == $past(count) - 1'b1)) else $error("pop count"); // R6
endmodule

// File: rtl/pport_hshk.sv
module pport_hshk
    import pport_pkg::*;
#(
    parameter int ACK_W = 200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              strobe_fall,
    input  logic [BYTE_W-1:0] cap_data,
    input  logic              fifo_full,
    output logic              push_vld,
    output logic [BYTE_W-1:0] push_data,
    output logic              ack_n,
    output logic              hs_busy
);
    localparam int AKW = cnt_w(ACK_W);
    localparam logic [AKW-1:0] ACK_LAST = AKW'(ACK_W - 1);

    hs_state_t         state;
    logic [AKW-1:0]    ack_cnt;
    logic [BYTE_W-1:0] hold;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            state   <= HS_IDLE;
            ack_cnt <= '0;
            hold    <= '0;
        end else begin
            case (state)
                HS_IDLE: if (strobe_fall) begin
                    hold  <= cap_data;
                    state <= HS_HOLD;
                end
                HS_HOLD: if (!fifo_full) begin
                    ack_cnt <= ACK_LAST;
                    state   <= HS_ACK;
                end
                HS_ACK: begin
                    if (ack_cnt == '0) state <= HS_IDLE;
                    else               ack_cnt <= ack_cnt - 1'b1;
                end
                default: state <= HS_IDLE;
            endcase
        end
    end

    assign push_vld  = (state == HS_HOLD);
    assign push_data = hold;
    assign ack_n     = (state != HS_ACK);
    assign hs_busy   = (state != HS_IDLE);

    AST_BUSY_ON_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (strobe_fall && !hs_busy && !flush) |=> hs_busy) else $error("busy late"); // R2
    AST_ACK_AFTER_STORE: assert property (@(posedge clk) disable iff (rst)
        $fell(ack_n) |-> $past(push_vld && !fifo_full)) else $error("ack before store"); // R4
    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (push_vld && fifo_full && !flush) |=> (ack_n && hs_busy)) else $error("ack while full"); // R5
    AST_STROBE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (strobe_fall && (state == HS_ACK) && !flush && (ack_cnt != '0)) |=> (state == HS_ACK)) else $error("strobe taken"); // R11
endmodule

// File: rtl/pport_rx.sv
module pport_rx
    import pport_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int ACK_W = 200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              iprime_en,
    input  logic              strobe_n,
    input  logic [BYTE_W-1:0] data_in,
    input  logic              init_n,
    input  logic              selin_n,
    input  logic              autofd_n,
    input  logic              paper_out,
    input  logic              online,
    input  logic              fault,
    output logic              busy,
    output logic              ack_n,
    output logic              pe,
    output logic              sel,
    output logic              fault_n,
    output logic              host_select,
    output logic              autofeed,
    output logic              reset_req,
    output logic              rd_valid,
    output logic [BYTE_W-1:0] rd_data,
    input  logic              rd_ready
);
    host_lines_t       raw;
    host_lines_t       syn;
    logic              strb_prev;
    logic              init_prev;
    logic              strobe_fall;
    logic              init_fall;
    logic              flush;
    logic              reset_req_q;
    logic              push_vld;
    logic [BYTE_W-1:0] push_data;
    logic              fifo_full;
    logic              hs_busy;

    assign raw = '{strobe_n: strobe_n, init_n: init_n, selin_n: selin_n,
                   autofd_n: autofd_n, data: data_in};

    pport_sync #(.W(HOST_W), .RST_VAL(HOST_IDLE)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (syn)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            strb_prev   <= 1'b1;
            init_prev   <= 1'b1;
            reset_req_q <= 1'b0;
        end else begin
            strb_prev   <= syn.strobe_n;
            init_prev   <= syn.init_n;
            reset_req_q <= iprime_en & init_fall;
        end
    end

    assign strobe_fall = strb_prev & ~syn.strobe_n;
    assign init_fall   = init_prev & ~syn.init_n;
    assign flush       = iprime_en & ~syn.init_n;

    pport_hshk #(.ACK_W(ACK_W)) u_hshk (
        .clk         (clk),
        .rst         (rst),
        .flush       (flush),
        .strobe_fall (strobe_fall),
        .cap_data    (syn.data),
        .fifo_full   (fifo_full),
        .push_vld    (push_vld),
        .push_data   (push_data),
        .ack_n       (ack_n),
        .hs_busy     (hs_busy)
    );

    pport_fifo #(.WIDTH(BYTE_W), .DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .wr_en    (push_vld),
        .wr_data  (push_data),
        .full     (fifo_full),
        .rd_valid (rd_valid),
        .rd_data  (rd_data),
        .rd_ready (rd_ready)
    );

    assign busy        = hs_busy | paper_out | fault;
    assign pe          = paper_out;
    assign sel         = online;
    assign fault_n     = ~fault;
    assign host_select = ~syn.selin_n;
    assign autofeed    = ~syn.autofd_n;
    assign reset_req   = reset_req_q;

    AST_FAULT_BUSY: assert property (@(posedge clk) disable iff (rst)
        (paper_out || fault) |-> busy) else $error("busy low in fault"); // R9
    AST_ACK_IMPLIES_BUSY: assert property (@(posedge clk) disable iff (rst)
        !ack_n |-> busy) else $error("ack without busy"); // R4
    AST_RESET_REQ_PULSE: assert property (@(posedge clk) disable iff (rst)
        reset_req |=> !reset_req) else $error("reset_req too long"); // R7
    AST_IPRIME_GATE: assert property (@(posedge clk) disable iff (rst)
        reset_req |-> $past(iprime_en)) else $error("reset_req while disabled"); // R8
endmodule

// File: tb/pport_rx_bench.sv
`timescale 1ns/1ps
module pport_rx_bench;
    localparam int DEPTH = 4;
    localparam int ACK_W = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       iprime_en = 1'b0;
    logic       strobe_n = 1'b1;
    logic [7:0] data_in = 8'h00;
    logic       init_n = 1'b1;
    logic       selin_n = 1'b1;
    logic       autofd_n = 1'b1;
    logic       paper_out = 1'b0;
    logic       online = 1'b1;
    logic       fault = 1'b0;
    logic       rd_ready = 1'b0;
    logic       busy, ack_n, pe, sel, fault_n, host_select, autofeed, reset_req, rd_valid;
    logic [7:0] rd_data;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    pport_rx #(.DEPTH(DEPTH), .ACK_W(ACK_W)) u_pport_rx (
        .clk(clk), .rst(rst), .iprime_en(iprime_en), .strobe_n(strobe_n),
        .data_in(data_in), .init_n(init_n), .selin_n(selin_n), .autofd_n(autofd_n),
        .paper_out(paper_out), .online(online), .fault(fault), .busy(busy),
        .ack_n(ack_n), .pe(pe), .sel(sel), .fault_n(fault_n),
        .host_select(host_select), .autofeed(autofeed), .reset_req(reset_req),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_ready(rd_ready)
    );

    task automatic chk(input string req, input string what, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, got, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [7:0] mq[$];
    int  m_phase;   // 0 idle, 1 holding, 2 acknowledging
    int  m_cnt;
    logic [7:0] m_hold;
    logic s_h1, s_h2, s_h3, i_h1, i_h2, i_h3, sel_h1, sel_h2, af_h1, af_h2;
    logic [7:0] d_h1, d_h2;
    logic m_rreq;

    always @(posedge clk) begin
        if (rst) begin
            mq.delete();
            m_phase = 0; m_cnt = 0; m_hold = 8'h00; m_rreq = 1'b0;
            {s_h1, s_h2, s_h3, i_h1, i_h2, i_h3} = 6'b111111;
            {sel_h1, sel_h2, af_h1, af_h2} = 4'b1111;
            d_h1 = 8'h00; d_h2 = 8'h00;
        end else begin
            int pre_size;
            pre_size = mq.size();
            m_rreq = iprime_en && i_h3 && !i_h2;
            if (iprime_en && !i_h2) begin
                mq.delete();
                m_phase = 0;
            end else begin
                if (rd_ready && pre_size > 0) void'(mq.pop_front());
                if (m_phase == 0) begin
                    if (s_h3 && !s_h2) begin m_phase = 1; m_hold = d_h2; end
                end else if (m_phase == 1) begin
                    if (pre_size < DEPTH) begin
                        mq.push_back(m_hold); m_phase = 2; m_cnt = ACK_W - 1;
                    end
                end else begin
                    if (m_cnt == 0) m_phase = 0; else m_cnt--;
                end
            end
            s_h3 = s_h2; s_h2 = s_h1; s_h1 = strobe_n;
            i_h3 = i_h2; i_h2 = i_h1; i_h1 = init_n;
            sel_h2 = sel_h1; sel_h1 = selin_n;
            af_h2 = af_h1; af_h1 = autofd_n;
            d_h2 = d_h1; d_h1 = data_in;
        end
    end

    // compare every clock, away from the active edge
    logic [7:0] got_q[$];
    always @(negedge clk) begin
        if (!rst) begin
            chk("R2", "busy", int'(busy), int'((m_phase != 0) || paper_out || fault));
            chk("R4", "ack_n", int'(ack_n), int'(m_phase != 2));
            chk("R3", "rd_valid", int'(rd_valid), int'(mq.size() > 0));
            if (mq.size() > 0) chk("R6", "rd_data", int'(rd_data), int'(mq[0]));
            chk("R7", "reset_req", int'(reset_req), int'(m_rreq));
            chk("R9", "pe", int'(pe), int'(paper_out));
            chk("R9", "sel", int'(sel), int'(online));
            chk("R9", "fault_n", int'(fault_n), int'(!fault));
            chk("R10", "host_select", int'(host_select), int'(!sel_h2));
            chk("R10", "autofeed", int'(autofeed), int'(!af_h2));
            if (rd_valid && rd_ready) got_q.push_back(rd_data);
        end
    end

    task automatic step(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic send(input logic [7:0] b, input int gap);
        data_in = b;
        step(1);
        strobe_n = 1'b0;
        step(3);
        strobe_n = 1'b1;
        step(gap);
    endtask

    task automatic drain_and_compare(input string req, input logic [7:0] exp[$]);
        got_q.delete();
        rd_ready = 1'b1;
        step(DEPTH + 4);
        rd_ready = 1'b0;
        step(1);
        chk(req, "drained count", got_q.size(), exp.size());
        foreach (exp[i]) begin
            if (i < got_q.size()) chk(req, "drained byte", int'(got_q[i]), int'(exp[i]));
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : stim
        logic [7:0] exp_q[$];
        step(3);
        rst = 1'b0;
        #1;
        // R12: reset state
        chk("R12", "busy", int'(busy), 0);
        chk("R12", "ack_n", int'(ack_n), 1);
        chk("R12", "rd_valid", int'(rd_valid), 0);
        chk("R12", "reset_req", int'(reset_req), 0);
        step(2);

        // R1: timing of busy after host strobe fall
        data_in = 8'hA5; step(1);
        strobe_n = 1'b0; step(2);
        chk("R1", "busy before capture", int'(busy), 0);
        step(1);
        chk("R1", "busy at capture", int'(busy), 1);
        step(2); strobe_n = 1'b1; step(ACK_W + 4);

        send(8'h3C, ACK_W + 6);
        // R11: second strobe arrives during the acknowledge of the first
        send(8'h11, 2);
        send(8'h22, ACK_W + 6);
        send(8'h44, ACK_W + 6);
        // R5: FIFO now full, fifth byte must wait
        send(8'h55, 20);
        chk("R5", "busy while full", int'(busy), 1);
        chk("R5", "ack_n while full", int'(ack_n), 1);
        exp_q = '{8'hA5, 8'h3C, 8'h11, 8'h44, 8'h55};
        drain_and_compare("R11", exp_q);
        step(ACK_W + 2);
        chk("R5", "busy released", int'(busy), 0);

        // R9: status lines
        paper_out = 1'b1; step(3);
        chk("R9", "busy on paper out", int'(busy), 1);
        paper_out = 1'b0; fault = 1'b1; online = 1'b0; step(3);
        fault = 1'b0; online = 1'b1; step(2);

        // R10: select-in and auto-feed
        selin_n = 1'b0; step(3); autofd_n = 1'b0; step(3);
        selin_n = 1'b1; autofd_n = 1'b1; step(3);

        // R8: input-prime disabled
        iprime_en = 1'b0;
        send(8'h66, ACK_W + 6);
        init_n = 1'b0; step(5); init_n = 1'b1; step(5);
        chk("R8", "rd_valid kept", int'(rd_valid), 1);
        chk("R8", "reset_req", int'(reset_req), 0);

        // R7: input-prime enabled during a handshake
        iprime_en = 1'b1;
        data_in = 8'h77; step(1);
        strobe_n = 1'b0; step(3);
        init_n = 1'b0; strobe_n = 1'b1; step(6);
        init_n = 1'b1; step(6);
        chk("R7", "rd_valid after flush", int'(rd_valid), 0);
        chk("R7", "busy after flush", int'(busy), 0);
        send(8'h88, ACK_W + 6);
        exp_q = '{8'h88};
        drain_and_compare("R7", exp_q);
        step(4);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule